// File: doc/BRIEF.md
# Framed Serial Control Word Receiver

This block takes an 8-bit control word from a three-wire serial link made of a serial clock, a data line and an active-high enable. A much faster system clock samples all three lines. Each line passes through a synchronizer chain, and edges are detected in the system domain. While enable is high, the data line is captured on every rising edge of the serial clock. The first bit captured becomes bit 0 of the word. After the eighth bit the block captures nothing more. When enable falls, a complete word is copied to the parallel output and a one-cycle valid strobe is raised. A frame that ends short is dropped, the output keeps its old value, and a one-cycle abort pulse is raised.

The control sequence is a three-state machine. `RX_IDLE` waits for enable to rise. That transition, *open*, clears the bit count and enters `RX_SHIFT`. In `RX_SHIFT`, a serial clock rise that brings in the eighth bit is the transition *fill*, which leads to `RX_FULL`. An enable fall in `RX_SHIFT` with fewer than eight bits is the transition *drop*, which returns to `RX_IDLE` with an abort pulse. An enable fall in `RX_FULL` is the transition *commit*, which returns to `RX_IDLE`, loads the output and pulses valid. If *fill* and an enable fall land in the same system cycle, the transition *commit* is taken straight from `RX_SHIFT`.

The serial clock must run at least 8 times slower than the system clock. The serial clock may rest high or low between frames.

Top module: `ser_ctl_rx`

## Requirements
- R1: The first data bit captured in a frame lands in bit 0 of `word_o`, and the eighth lands in bit 7.
- R2: The data line is captured only on rising edges of `ser_clk_i` while `ser_en_i` is high. Serial clock edges while enable is low have no effect on `word_o` or on either pulse output.
- R3: When `ser_en_i` falls after eight bits, `word_o` takes the received word. The update appears at the third system clock edge at which `ser_en_i` is sampled low.
- R4: When `ser_en_i` falls after fewer than eight bits, `word_o` keeps its previous value.
- R5: Rising edges of `ser_clk_i` after the eighth in a frame are ignored, and the first eight bits are committed. The bit counter never exceeds 8 and equals 8 in `RX_FULL`.
- R6: `word_vld_o` is high for exactly one cycle for each committed word. `frame_abort_o` is high for exactly one cycle for each dropped frame. The two are never high together.
- R7: If the eighth rising serial clock edge and the enable fall are detected in the same system cycle, the frame commits with that eighth bit included.
- R8: A frame is received correctly whether the serial clock rests high or low while enable is low.
- R9: Synchronous active-high `rst` clears `word_o` to zero, keeps both pulses low and returns the machine to `RX_IDLE`. This also holds in the middle of a frame.
- R10: Each rising edge of enable starts a new frame from a zero count, so a full frame that follows a dropped one commits correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data captured on its rising edge |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| ser_en_i | input | 1 | Active-high frame enable |
| word_o | output | 8 | Last committed control word |
| word_vld_o | output | 1 | One-cycle strobe when `word_o` is loaded |
| frame_abort_o | output | 1 | One-cycle pulse when a short frame is dropped |

## Verification
Two of this block's functions can fall in the same cycle: capture of the eighth bit and the frame-closing decision. When both edges reach the system domain together, the block must treat the bit as captured before it judges whether the frame is complete. The bench provokes this by raising the serial clock for the eighth bit and dropping enable on the same system clock cycle. It then checks that the word commits with that bit, that no abort pulse appears, and that the strobe arrives on the cycle the behavioural model predicts.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_e;

    // lane positions inside the synchronizer vector
    localparam int LN_CLK   = 0;
    localparam int LN_DAT   = 1;
    localparam int LN_EN    = 2;
    localparam int LN_COUNT = 3;

    typedef struct packed {
        logic sclk_rise;
        logic en_rise;
        logic en_fall;
    } link_ev_t;

endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] pin_i,
    output logic [LANES-1:0] lvl_o
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], pin_i[g]};
                end
            end

            assign lvl_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ser_ctl_edge.sv
module ser_ctl_edge
    import ser_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_lvl_i,
    input  logic     en_lvl_i,
    output link_ev_t ev_o
);

    logic sclk_q;
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_lvl_i;
            en_q   <= en_lvl_i;
        end
    end

    always_comb begin
        ev_o.sclk_rise = sclk_lvl_i & ~sclk_q;
        ev_o.en_rise   = en_lvl_i & ~en_q;
        ev_o.en_fall   = ~en_lvl_i & en_q;
    end

endmodule

// File: rtl/ser_ctl_shift.sv
module ser_ctl_shift #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              take_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] next_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              last_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full;
    logic              step;

    assign full = (cnt_q == CNT_FULL);
    assign step = take_i & ~full;

    // right shift: after WORD_W steps the first bit sits in bit 0
    always_comb begin
        if (step) begin
            next_o = {bit_i, sh_q[WORD_W-1:1]};
        end else begin
            next_o = sh_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (step) begin
            sh_q  <= next_o;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/ser_ctl_fsm.sv
module ser_ctl_fsm
    import ser_ctl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  link_ev_t          ev_i,
    input  logic              last_i,
    input  logic [WORD_W-1:0] word_next_i,
    output logic              restart_o,
    output logic              take_o,
    output rx_state_e         state_o,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o,
    output logic              abort_o
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      fill;
    logic      commit;
    logic      drop;

    assign fill = ev_i.sclk_rise & last_i;

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (ev_i.en_rise) begin
                    state_d = RX_SHIFT;           // open
                end
            end
            RX_SHIFT: begin
                if (ev_i.en_fall) begin
                    state_d = RX_IDLE;
                    if (fill) begin
                        commit = 1'b1;            // commit, same cycle as fill
                    end else begin
                        drop = 1'b1;              // drop
                    end
                end else if (fill) begin
                    state_d = RX_FULL;            // fill
                end
            end
            RX_FULL: begin
                if (ev_i.en_fall) begin
                    state_d = RX_IDLE;            // commit
                    commit  = 1'b1;
                end
            end
            default: begin
                state_d = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            vld_o   <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            vld_o   <= commit;
            abort_o <= drop;
            if (commit) begin
                word_o <= word_next_i;
            end
        end
    end

    assign restart_o = (state_q == RX_IDLE) & ev_i.en_rise;
    assign take_o    = (state_q != RX_IDLE) & ev_i.sclk_rise;
    assign state_o   = state_q;

endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx
    import ser_ctl_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              frame_abort_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [LN_COUNT-1:0] pins;
    logic [LN_COUNT-1:0] lvl;
    link_ev_t            ev;
    logic                restart;
    logic                take;
    logic                last_bit;
    logic [WORD_W-1:0]   word_next;
    logic [CNT_W-1:0]    bit_cnt;
    rx_state_e           state;

    always_comb begin
        pins         = '0;
        pins[LN_CLK] = ser_clk_i;
        pins[LN_DAT] = ser_dat_i;
        pins[LN_EN]  = ser_en_i;
    end

    ser_ctl_sync #(
        .LANES (LN_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin_i(pins),
        .lvl_o(lvl)
    );

    ser_ctl_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk_lvl_i(lvl[LN_CLK]),
        .en_lvl_i  (lvl[LN_EN]),
        .ev_o      (ev)
    );

    ser_ctl_shift #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .restart_i(restart),
        .take_i   (take),
        .bit_i    (lvl[LN_DAT]),
        .next_o   (word_next),
        .cnt_o    (bit_cnt),
        .last_o   (last_bit)
    );

    ser_ctl_fsm #(
        .WORD_W(WORD_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .last_i     (last_bit),
        .word_next_i(word_next),
        .restart_o  (restart),
        .take_o     (take),
        .state_o    (state),
        .word_o     (word_o),
        .vld_o      (word_vld_o),
        .abort_o    (frame_abort_o)
    );

endmodule

// File: rtl/ser_ctl_rx_chk.sv
module ser_ctl_rx_chk
    import ser_ctl_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              frame_abort_o,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  cnt
);

    // R6: strobe and abort are exclusive
    a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(word_vld_o && frame_abort_o));

    // R6: strobe lasts one cycle
    a_r6_vld_single: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |=> !word_vld_o);

    // R6: abort lasts one cycle
    a_r6_abort_single: assert property (@(posedge clk) disable iff (rst)
        frame_abort_o |=> !frame_abort_o);

    // R4: output word moves only together with the strobe
    a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_o) |-> word_vld_o);

    // R5: counter bounded
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W));

    // R5: full state means a complete count
    a_r5_full_count: assert property (@(posedge clk) disable iff (rst)
        (state == RX_FULL) |-> (cnt == CNT_W'(WORD_W)));

    // R3: after a commit or drop the machine is idle
    a_r3_idle_after_close: assert property (@(posedge clk) disable iff (rst)
        (word_vld_o || frame_abort_o) |-> (state == RX_IDLE));

    // R9: reset clears word, pulses and state
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (word_o == '0 && !word_vld_o && !frame_abort_o && state == RX_IDLE));

endmodule

bind ser_ctl_rx ser_ctl_rx_chk #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_o       (word_o),
    .word_vld_o   (word_vld_o),
    .frame_abort_o(frame_abort_o),
    .state        (state),
    .cnt          (bit_cnt)
);

// File: tb/test_ser_ctl_rx.sv
module test_ser_ctl_rx;

    logic       clk;
    logic       rst;
    logic       sclk;
    logic       sdat;
    logic       sen;
    logic [7:0] word_o;
    logic       word_vld_o;
    logic       frame_abort_o;

    int n_total = 0;
    int n_bad   = 0;
    int n_vld   = 0;
    int n_abt   = 0;
    bit started = 0;
    bit done    = 0;

    // behavioural model state
    logic [2:0] hist[$];
    bit         m_act;
    int         m_cnt;
    logic [7:0] m_sh;
    logic [7:0] m_word;
    logic       m_vld;
    logic       m_abt;

    ser_ctl_rx i_ser_ctl_rx (
        .clk          (clk),
        .rst          (rst),
        .ser_clk_i    (sclk),
        .ser_dat_i    (sdat),
        .ser_en_i     (sen),
        .word_o       (word_o),
        .word_vld_o   (word_vld_o),
        .frame_abort_o(frame_abort_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model: pins pass two sync stages, then edge compare against one more
    always @(posedge clk) begin
        logic r_clk, p_clk, r_dat, r_en, p_en;
        started <= 1'b1;
        if (rst) begin
            hist   = {3'b000, 3'b000, 3'b000};
            m_act  = 0;
            m_cnt  = 0;
            m_word = 8'h00;
            m_vld  = 1'b0;
            m_abt  = 1'b0;
        end else begin
            r_clk = hist[1][0];
            p_clk = hist[0][0];
            r_dat = hist[1][1];
            r_en  = hist[1][2];
            p_en  = hist[0][2];
            m_vld = 1'b0;
            m_abt = 1'b0;
            if (!m_act) begin
                if (r_en && !p_en) begin
                    m_act = 1;
                    m_cnt = 0;
                end
            end else begin
                if (r_clk && !p_clk && m_cnt < 8) begin
                    m_sh[m_cnt] = r_dat;
                    m_cnt++;
                end
                if (!r_en && p_en) begin
                    if (m_cnt == 8) begin
                        m_word = m_sh;
                        m_vld  = 1'b1;
                    end else begin
                        m_abt = 1'b1;
                    end
                    m_act = 0;
                end
            end
            void'(hist.pop_front());
            hist.push_back({sen, sdat, sclk});
        end
    end

    // per-cycle comparison and pulse counting
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 word vs model", int'(word_o), int'(m_word));
            chk("R6 strobe vs model", int'(word_vld_o), int'(m_vld));
            chk("R6 abort vs model", int'(frame_abort_o), int'(m_abt));
            if (word_vld_o) n_vld++;
            if (frame_abort_o) n_abt++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send nbits LSB first; together=1 drops enable with the last rising edge
    task automatic send(input logic [15:0] bits, input int nbits,
                        input bit idle_hi, input bit together);
        sclk = idle_hi;
        sen  = 1'b0;
        wait_cyc(4);
        sen = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdat = bits[i];
            wait_cyc(4);
            sclk = 1'b1;
            if (together && i == nbits - 1) begin
                sen = 1'b0;
            end
            wait_cyc(4);
        end
        if (!idle_hi) begin
            sclk = 1'b0;
            wait_cyc(4);
        end
        sen = 1'b0;
        wait_cyc(10);
        sclk = idle_hi;
        wait_cyc(4);
    endtask

    initial begin
        int v0, a0;
        rst  = 1'b1;
        sclk = 1'b0;
        sdat = 1'b0;
        sen  = 1'b0;
        wait_cyc(4);
        chk("R9 reset word", int'(word_o), 0);
        chk("R9 reset strobe", int'(word_vld_o), 0);
        chk("R9 reset abort", int'(frame_abort_o), 0);
        rst = 1'b0;
        wait_cyc(4);

        // R1 / R3: full frame, clock rests low
        v0 = n_vld;
        send(16'h00A5, 8, 1'b0, 1'b0);
        chk("R1 lsb first word", int'(word_o), 'hA5);
        chk("R6 one strobe", n_vld - v0, 1);

        // R8: clock rests high
        send(16'h003C, 8, 1'b1, 1'b0);
        chk("R8 idle-high word", int'(word_o), 'h3C);

        // R4: short frame dropped
        a0 = n_abt;
        v0 = n_vld;
        send(16'h001F, 5, 1'b0, 1'b0);
        chk("R4 word kept", int'(word_o), 'h3C);
        chk("R4 abort pulse", n_abt - a0, 1);
        chk("R4 no strobe", n_vld - v0, 0);

        // R5 / R10: over-long frame right after a drop
        send(16'h0796, 11, 1'b0, 1'b0);
        chk("R5 extra bits ignored", int'(word_o), 'h96);
        chk("R10 frame after drop", n_vld - v0, 1);

        // R2: serial clock activity with enable low
        v0 = n_vld;
        a0 = n_abt;
        sdat = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(4);
        end
        wait_cyc(6);
        chk("R2 word unchanged", int'(word_o), 'h96);
        chk("R2 no pulses", (n_vld - v0) + (n_abt - a0), 0);
        send(16'h0000, 8, 1'b0, 1'b0);
        chk("R2 frame after idle clocks", int'(word_o), 'h00);

        // R7: eighth rise and enable fall in the same cycle
        v0 = n_vld;
        a0 = n_abt;
        send(16'h00C3, 8, 1'b0, 1'b1);
        chk("R7 same-cycle commit", int'(word_o), 'hC3);
        chk("R7 strobe", n_vld - v0, 1);
        chk("R7 no abort", n_abt - a0, 0);

        // R9: reset in the middle of a frame
        a0 = n_abt;
        sen = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < 4; i++) begin
            sdat = 1'b1;
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(4);
        end
        rst = 1'b1;
        wait_cyc(2);
        sen = 1'b0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(8);
        chk("R9 mid-frame reset word", int'(word_o), 0);
        chk("R9 no abort after reset", n_abt - a0, 0);

        send(16'h005A, 8, 1'b1, 1'b0);
        chk("R3 frame after reset", int'(word_o), 'h5A);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule